// File: doc/BRIEF.md
# Configuration Word Copy Sequencer

This block runs during the tune phase of a radio receiver's control logic. When started, it fetches 16-bit configuration words one at a time from a nonvolatile word store, and writes each word as bytes into the 8-bit configuration register bank. Each word occupies two adjacent register addresses. Its low byte goes to the even address and its high byte to the odd address that follows. The new configuration counts as loaded only once the sequencer reports completion.

The sequencer can skip the copy, depending on why the tune phase began. After a power-on reset the store is always copied. After a soft reset with the retain option set, the register bank keeps what it holds and the sequencer finishes at once. The store holds more words than the bank needs, and the words past the copied range are never fetched.

Top module: `cfg_copy_engine`

## Requirements
- R1: A copy run fetches words 0 to 12 in rising order and writes every register address from 0x00 to 0x19 exactly once. It writes no other address.
- R2: For word index n, bits [7:0] are written to address 2n and bits [15:8] to address 2n+1.
- R3: The even address of a word is written in the cycle after that word's read is accepted. The odd address is written in the very next cycle. Only one byte is written per cycle.
- R4: A read request never carries a word index of 13 or higher.
- R5: A start with por_flag_i=0 and retain_i=1 issues no read and no write. done_o pulses in the cycle after start, and the register bank keeps its contents.
- R6: A start with por_flag_i=1 runs the copy whatever retain_i is. A start with por_flag_i=0 and retain_i=0 also runs the copy.
- R7: While a word is being waited for, rd_req_o stays high with a stable rd_addr_o and nothing is written. A read is accepted only in a cycle where rd_req_o and rd_valid_i are both high.
- R8: After a copy run, done_o pulses for one cycle, in the cycle after the last odd-address write. No write occurs together with done_o.
- R9: A start that arrives while a run is in progress is ignored. The run finishes with exactly 26 writes.
- R10: After a synchronous reset, rd_req_o, wr_en_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins the tune-phase copy |
| por_flag_i | input | 1 | 1 when the tune phase follows a power-on reset, 0 when it follows a soft reset |
| retain_i | input | 1 | Retain option: keeps the registers after a soft reset |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 4 | Word index being requested |
| rd_valid_i | input | 1 | Read data valid, accepted while rd_req_o is high |
| rd_data_i | input | 16 | Word read from the store |
| wr_en_o | output | 1 | Register bank byte write strobe |
| wr_addr_o | output | 8 | Register bank byte address |
| wr_data_o | output | 8 | Register bank byte data |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong word counter shows up within one cycle as a wrong rd_addr_o, and within two cycles as bytes landing at the wrong pair of addresses. A wrong lane counter swaps or duplicates bytes inside a pair. This is caught at the next write strobe. A wrong skip decision shows up in the very next cycle, either as a read request where done_o was expected, or as done_o where a read request was expected. The bench's cycle model compares every output on every clock, so each of these faults appears at most two cycles after it arises.

// File: rtl/cfg_copy_pkg.sv
package cfg_copy_pkg;
  typedef enum logic [1:0] {
    CP_IDLE = 2'd0,
    CP_WAIT = 2'd1,
    CP_LANE = 2'd2,
    CP_FIN  = 2'd3
  } cp_state_e;
endpackage

// File: rtl/cfg_copy_gate.sv
module cfg_copy_gate (
  input  logic por_flag_i,
  input  logic retain_i,
  output logic run_o
);
  // A power-on reset always forces a copy; a soft reset copies unless retained.
  assign run_o = por_flag_i | ~retain_i;
endmodule

// File: rtl/cfg_word_counter.sv
module cfg_word_counter #(
  parameter int NUM_WORDS = 13,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      idx_o <= '0;
    end else if (step_i) begin
      idx_o <= idx_o + IDX_W'(1);
    end
  end

  assign last_o = (idx_o == LAST_IDX);
endmodule

// File: rtl/cfg_lane_mux.sv
module cfg_lane_mux #(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  parameter int LANES  = WORD_W / BYTE_W,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [LANE_W-1:0] lane_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/cfg_copy_engine.sv
module cfg_copy_engine #(
  parameter int WORD_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int NUM_WORDS   = 13,
  parameter int STORE_DEPTH = 16,
  parameter int ADDR_W      = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic                           por_flag_i,
  input  logic                           retain_i,
  output logic                           rd_req_o,
  output logic [$clog2(STORE_DEPTH)-1:0] rd_addr_o,
  input  logic                           rd_valid_i,
  input  logic [WORD_W-1:0]              rd_data_i,
  output logic                           wr_en_o,
  output logic [ADDR_W-1:0]              wr_addr_o,
  output logic [BYTE_W-1:0]              wr_data_o,
  output logic                           done_o
);
  import cfg_copy_pkg::*;

  localparam int LANES  = WORD_W / BYTE_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int IDX_W  = $clog2(STORE_DEPTH);
  localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(LANES - 1);

  cp_state_e         state_q;
  logic [LANE_W-1:0] lane_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx;
  logic              last_word;
  logic              run_copy;
  logic              cnt_clear;
  logic              cnt_step;
  logic [BYTE_W-1:0] lane_byte;
  logic              busy;

  function automatic logic [ADDR_W-1:0] byte_addr(input logic [IDX_W-1:0] w,
                                                   input logic [LANE_W-1:0] l);
    return ADDR_W'(w) * ADDR_W'(LANES) + ADDR_W'(l);
  endfunction

  cfg_copy_gate u_gate (
    .por_flag_i (por_flag_i),
    .retain_i   (retain_i),
    .run_o      (run_copy)
  );

  cfg_word_counter #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear_i (cnt_clear),
    .step_i  (cnt_step),
    .idx_o   (idx),
    .last_o  (last_word)
  );

  cfg_lane_mux #(
    .WORD_W (WORD_W),
    .BYTE_W (BYTE_W),
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_mux (
    .word_i (word_q),
    .lane_i (lane_q),
    .byte_o (lane_byte)
  );

  assign cnt_clear = (state_q == CP_IDLE) && start_i && run_copy;
  assign cnt_step  = (state_q == CP_LANE) && (lane_q == TOP_LANE) && !last_word;
  assign busy      = (state_q != CP_IDLE);
  assign rd_req_o  = (state_q == CP_WAIT);
  assign rd_addr_o = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= CP_IDLE;
      lane_q    <= '0;
      word_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o <= 1'b0;
      done_o  <= 1'b0;
      unique case (state_q)
        CP_IDLE: begin
          if (start_i) begin
            if (run_copy) state_q <= CP_WAIT;
            else          done_o  <= 1'b1;
          end
        end
        CP_WAIT: begin
          if (rd_valid_i) begin
            word_q    <= rd_data_i;
            wr_en_o   <= 1'b1;
            wr_addr_o <= byte_addr(idx, '0);
            wr_data_o <= rd_data_i[BYTE_W-1:0];
            lane_q    <= LANE_W'(1);
            state_q   <= CP_LANE;
          end
        end
        CP_LANE: begin
          wr_en_o   <= 1'b1;
          wr_addr_o <= byte_addr(idx, lane_q);
          wr_data_o <= lane_byte;
          if (lane_q == TOP_LANE) begin
            state_q <= last_word ? CP_FIN : CP_WAIT;
          end else begin
            lane_q <= lane_q + LANE_W'(1);
          end
        end
        CP_FIN: begin
          done_o  <= 1'b1;
          state_q <= CP_IDLE;
        end
        default: state_q <= CP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_copy_engine_chk.sv
module cfg_copy_engine_chk #(
  parameter int NUM_WORDS = 13,
  parameter int LANES     = 2,
  parameter int IDX_W     = 4,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              por_flag_i,
  input logic              retain_i,
  input logic              rd_req_o,
  input logic [IDX_W-1:0]  rd_addr_o,
  input logic              rd_valid_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              done_o,
  input logic              busy
);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(NUM_WORDS * LANES);
  localparam logic [IDX_W-1:0]  IDX_END  = IDX_W'(NUM_WORDS);
  localparam logic [ADDR_W-1:0] LN       = ADDR_W'(LANES);
  localparam logic [ADDR_W-1:0] LN_TOP   = ADDR_W'(LANES - 1);

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_addr_o < ADDR_END)); // R1

  AST_REQ_IDX_LIMIT: assert property (@(posedge clk) disable iff (rst)
    rd_req_o |-> (rd_addr_o < IDX_END)); // R4

  AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && ((wr_addr_o % LN) != LN_TOP)) |=>
      (wr_en_o && (wr_addr_o == $past(wr_addr_o) + ADDR_W'(1)))); // R3

  AST_FIRST_LANE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && ((wr_addr_o % LN) == '0)) |-> $past(rd_req_o && rd_valid_i)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o) && !wr_en_o)); // R7

  AST_SKIP_RETAINED: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && !por_flag_i && retain_i) |=>
      (done_o && !rd_req_o && !wr_en_o)); // R5

  AST_RUN_STARTS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy && (por_flag_i || !retain_i)) |=> (rd_req_o && !done_o)); // R6

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!wr_en_o && !busy)); // R8
endmodule

bind cfg_copy_engine cfg_copy_engine_chk #(
  .NUM_WORDS (NUM_WORDS),
  .LANES     (WORD_W / BYTE_W),
  .IDX_W     ($clog2(STORE_DEPTH)),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .por_flag_i (por_flag_i),
  .retain_i   (retain_i),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .rd_valid_i (rd_valid_i),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .done_o     (done_o),
  .busy       (busy)
);

// File: tb/cfg_copy_engine_test.sv
module cfg_copy_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW    = 13;
  localparam int DEPTH = 16;
  localparam int BANK  = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        por_flag_i = 1'b0;
  logic        retain_i = 1'b0;
  logic        rd_req_o;
  logic [3:0]  rd_addr_o;
  logic        rd_valid_i = 1'b0;
  logic [15:0] rd_data_i = 16'h0;
  logic        wr_en_o;
  logic [7:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        done_o;

  int errors = 0;
  int checks = 0;
  int run_no = 0;
  int lat_cnt = 0;
  int wr_count = 0;
  int cycles = 0;
  bit finished = 0;

  logic [15:0] store [DEPTH];
  logic [7:0]  bank [BANK];
  logic [7:0]  exp_bank [BANK];

  // reference model state
  bit m_busy = 0, m_wait = 0, m_fin = 0;
  int widx = 0;
  logic [7:0] wq[$];
  bit e_wr = 0, e_done = 0;
  int e_addr = 0;
  logic [7:0] e_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_copy_engine uut (
    .clk(clk), .rst(rst), .start_i(start_i), .por_flag_i(por_flag_i),
    .retain_i(retain_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_wait = 0; m_fin = 0; widx = 0;
      wq.delete(); e_wr = 0; e_done = 0;
    end else begin
      e_wr = 0; e_done = 0;
      if (m_fin) begin
        e_done = 1; m_fin = 0; m_busy = 0;
      end else if (!m_busy) begin
        if (start_i) begin
          if (!por_flag_i && retain_i) e_done = 1;
          else begin m_busy = 1; m_wait = 1; widx = 0; end
        end
      end else begin
        if (m_wait && rd_valid_i) begin
          wq.push_back(store[widx][7:0]);
          wq.push_back(store[widx][15:8]);
          m_wait = 0;
        end
        if (wq.size() > 0) begin
          e_wr = 1;
          e_data = wq.pop_front();
          e_addr = 2 * widx + ((wq.size() == 1) ? 0 : 1);
          if (wq.size() == 0) begin
            if (widx == NW - 1) m_fin = 1;
            else begin widx++; m_wait = 1; end
          end
        end
      end
    end
  end

  // per-cycle comparison and bank capture
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R8", "done_o", int'(done_o), int'(e_done));
      check("R3", "wr_en_o", int'(wr_en_o), int'(e_wr));
      if (e_wr) begin
        check("R1", "wr_addr_o", int'(wr_addr_o), e_addr);
        check("R2", "wr_data_o", int'(wr_data_o), int'(e_data));
      end
      check("R7", "rd_req_o", int'(rd_req_o), int'(m_busy && m_wait));
      if (m_busy && m_wait) check("R4", "rd_addr_o", int'(rd_addr_o), widx);
      if (wr_en_o) begin
        bank[wr_addr_o[5:0]] = wr_data_o;
        wr_count++;
      end
    end
  end

  // word store responder with a latency that varies per word
  always @(negedge clk) begin
    if (rst) begin
      rd_valid_i <= 1'b0; lat_cnt = 0;
    end else if (rd_valid_i) begin
      rd_valid_i <= 1'b0; rd_data_i <= 16'hBEEF;
    end else if (rd_req_o) begin
      if (lat_cnt >= (int'(rd_addr_o) + run_no) % 4) begin
        rd_valid_i <= 1'b1; rd_data_i <= store[rd_addr_o]; lat_cnt = 0;
      end else lat_cnt++;
    end else lat_cnt = 0;
  end

  task automatic fill_store(input int seed);
    for (int i = 0; i < DEPTH; i++)
      store[i] = 16'((seed * 40503 + i * 2654 + 7) ^ (i << 9));
  endtask

  task automatic load_expected();
    for (int i = 0; i < NW; i++) begin
      exp_bank[2*i]   = store[i][7:0];
      exp_bank[2*i+1] = store[i][15:8];
    end
  endtask

  task automatic check_bank(input string req);
    int bad = 0;
    for (int a = 0; a < BANK; a++) if (bank[a] !== exp_bank[a]) bad++;
    check(req, "register bank mismatches", bad, 0);
  endtask

  task automatic run(input bit por, input bit ret, input int extra_start_at);
    int n = 0;
    run_no++;
    wr_count = 0;
    @(negedge clk);
    por_flag_i <= por; retain_i <= ret; start_i <= 1'b1;
    @(negedge clk);
    start_i <= 1'b0;
    while (!done_o && n < 1000) begin
      n++;
      if (n == extra_start_at) begin start_i <= 1'b1; por_flag_i <= 1'b0; retain_i <= 1'b1; end
      else start_i <= 1'b0;
      @(negedge clk);
    end
    start_i <= 1'b0;
    check("R8", "done seen before timeout", int'(done_o), 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < BANK; a++) begin bank[a] = 8'hEE; exp_bank[a] = 8'hEE; end
    fill_store(1);
    repeat (3) @(negedge clk);
    check("R10", "rd_req_o after reset", int'(rd_req_o), 0);
    check("R10", "wr_en_o after reset", int'(wr_en_o), 0);
    check("R10", "done_o after reset", int'(done_o), 0);
    rst <= 1'b0;
    @(negedge clk);

    // R1 R2 R4: power-on copy; addresses beyond 0x19 keep their sentinel
    run(1'b1, 1'b0, 0);
    load_expected();
    check_bank("R1");
    check("R1", "writes per run", wr_count, 2*NW);
    check("R4", "byte 0x1A untouched", int'(bank[26]), 8'hEE);

    // R5: soft reset with retain set skips the copy
    fill_store(2);
    run(1'b0, 1'b1, 0);
    check("R5", "writes in skipped run", wr_count, 0);
    check_bank("R5");

    // R6: power-on copy ignores retain
    run(1'b1, 1'b1, 0);
    load_expected();
    check_bank("R6");

    // R6: soft reset without retain copies
    fill_store(3);
    run(1'b0, 1'b0, 0);
    load_expected();
    check_bank("R6");

    // R9: start pulse in the middle of a run is ignored
    fill_store(4);
    run(1'b1, 1'b0, 9);
    load_expected();
    check("R9", "writes with mid-run start", wr_count, 2*NW);
    check_bank("R9");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule